// File: doc/BRIEF.md
# Pre-Charge Half-Buffer Token Stage

A dataless pipeline stage controller that moves tokens between an upstream channel and a downstream channel. Both channels use a four-phase, return-to-zero request/enable handshake. The enable signal is active-low as an acknowledge: a high enable means the receiving side can take a new token. The stage is written for a clocked simulation domain. It keeps three state nodes: an output request, a left-validity node and an internal gate enable. Each node moves only when its set or reset guard is true and holds its value otherwise.

A parameter selects one of two disciplines. In pre-charge mode, the separate gate enable lets the stage clear its output only after both enables have dropped. It then re-arms only after both enables have risen again. Weak-condition mode is a lighter variant: the output request simply follows the agreement of the upstream request and the downstream enable. Stages are chained by wiring one stage's output request to the next stage's input request, and that stage's input enable back to the previous stage's output enable.

Top module: `tok_stage`

## Requirements
- R1: After synchronous reset the stage is empty: `out_req` is 0 and `in_en` is 1, and the internal gate enable is 1.
- R2: In pre-charge mode `out_req` rises one clock after a cycle in which `in_req` is 1 and the gate enable is 1. It never rises from a cycle in which `in_req` is 0.
- R3: In pre-charge mode `in_en` falls one clock after a cycle in which both `in_req` and `out_req` are 1.
- R4: In pre-charge mode the gate enable falls one clock after a cycle with `in_en` and `out_en` both 0, and `out_req` falls on the following clock. A low `out_en` alone, while `in_en` is still 1, leaves `out_req` high.
- R5: In pre-charge mode `in_en` rises one clock after a cycle in which `in_req` and `out_req` are both 0. It stays low while either of them is 1.
- R6: In pre-charge mode the gate enable rises one clock after a cycle with `in_en` and `out_en` both 1. Until then `out_req` stays 0 even with `in_req` at 1.
- R7: In weak-condition mode `out_req` rises one clock after `in_req` and `out_en` are both 1, falls one clock after both are 0, and `in_en` is always the inverse of `out_req`.
- R8: A node whose set and reset guards are both false keeps its value. For example, a weak-mode stage holds `out_req` while `in_req` and `out_en` disagree.
- R9: The set guard and the reset guard of one node are never true in the same cycle.
- R10: A chain of stages driven by a four-phase producer and consumer delivers every token exactly once, in either mode, and is empty again once the producer stops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every guard is evaluated once per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | 1 | Request from the upstream stage |
| in_en | output | 1 | Enable to the upstream stage, 1 = ready, 0 = token accepted |
| out_req | output | 1 | Request to the downstream stage |
| out_en | input | 1 | Enable from the downstream stage, 1 = ready, 0 = token accepted |

## Verification
A wrong gate enable shows at `out_req` within two clocks. The output either drops while the upstream side still holds its token, or it rises before both enables have re-armed. Directed single-stage scenarios sample both outputs on every clock across those windows. A stuck or early left-validity node shows on `in_en` one clock after the offending request pattern. In a chain, such a node appears as a lost or repeated token, which the consumer counts against the producer.

// File: rtl/tok_pkg.sv
package tok_pkg;

    typedef enum logic {
        HB_PRECHARGE = 1'b0,
        HB_WEAK      = 1'b1
    } hb_mode_e;

    typedef struct packed {
        logic set;
        logic clr;
    } guard_t;

    typedef struct packed {
        logic gate;
        logic lvalid;
        logic oreq;
    } node_vec_t;

    localparam int NODE_CNT = $bits(node_vec_t);
    localparam int IX_GATE  = 2;
    localparam int IX_LV    = 1;
    localparam int IX_OREQ  = 0;

    localparam node_vec_t NODES_RESET = '{gate: 1'b1, lvalid: 1'b0, oreq: 1'b0};

    function automatic logic rule_next(input logic cur, input guard_t g);
        logic nxt;
        if (g.set)
            nxt = 1'b1;
        else if (g.clr)
            nxt = 1'b0;
        else
            nxt = cur;
        return nxt;
    endfunction

endpackage

// File: rtl/tok_node.sv
module tok_node
    import tok_pkg::*;
#(
    parameter logic RST_VAL = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  guard_t g,
    output logic   q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= RST_VAL;
        else
            q <= rule_next(q, g);
    end

endmodule

// File: rtl/tok_guards.sv
module tok_guards
    import tok_pkg::*;
#(
    parameter hb_mode_e MODE = HB_PRECHARGE
) (
    input  node_vec_t                cur,
    input  logic                     in_req,
    input  logic                     out_en,
    output guard_t [NODE_CNT-1:0]    g,
    output logic                     in_en
);

    generate
        if (MODE == HB_PRECHARGE) begin : g_pchb
            always_comb begin
                in_en           = ~cur.lvalid;
                g[IX_OREQ].set  = cur.gate & in_req;
                g[IX_OREQ].clr  = ~cur.gate;
                g[IX_LV].set    = in_req & cur.oreq & ~cur.lvalid;
                g[IX_LV].clr    = ~in_req & ~cur.oreq & cur.lvalid;
                g[IX_GATE].set  = ~cur.lvalid & out_en;
                g[IX_GATE].clr  = cur.lvalid & ~out_en;
            end
        end else begin : g_weak
            always_comb begin
                in_en           = ~cur.oreq;
                g[IX_OREQ].set  = out_en & in_req;
                g[IX_OREQ].clr  = ~out_en & ~in_req;
                g[IX_LV].set    = in_req & cur.oreq & ~cur.lvalid;
                g[IX_LV].clr    = ~in_req & ~cur.oreq & cur.lvalid;
                g[IX_GATE].set  = out_en & ~cur.gate;
                g[IX_GATE].clr  = ~out_en & cur.gate;
            end
        end
    endgenerate

endmodule

// File: rtl/tok_stage.sv
module tok_stage
    import tok_pkg::*;
#(
    parameter hb_mode_e MODE = HB_PRECHARGE
) (
    input  logic clk,
    input  logic rst,
    input  logic in_req,
    output logic in_en,
    output logic out_req,
    input  logic out_en
);

    localparam logic [NODE_CNT-1:0] RST_BITS = NODES_RESET;

    logic [NODE_CNT-1:0]   node_bits;
    node_vec_t             node_q;
    guard_t [NODE_CNT-1:0] guard_all;

    assign node_q = node_vec_t'(node_bits);

    tok_guards #(.MODE(MODE)) u_guards (
        .cur    (node_q),
        .in_req (in_req),
        .out_en (out_en),
        .g      (guard_all),
        .in_en  (in_en)
    );

    generate
        for (genvar i = 0; i < NODE_CNT; i++) begin : g_node
            tok_node #(.RST_VAL(RST_BITS[i])) u_node (
                .clk (clk),
                .rst (rst),
                .g   (guard_all[i]),
                .q   (node_bits[i])
            );
        end
    endgenerate

    assign out_req = node_q.oreq;

endmodule

// File: rtl/tok_stage_chk.sv
module tok_stage_chk
    import tok_pkg::*;
#(
    parameter hb_mode_e MODE = HB_PRECHARGE
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_req,
    input logic                  in_en,
    input logic                  out_req,
    input logic                  out_en,
    input node_vec_t             nodes,
    input guard_t [NODE_CNT-1:0] guards
);

    assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_req && in_en && nodes.gate));

    assert_req_needs_input_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(out_req) |-> $past(in_req));

    generate
        for (genvar i = 0; i < NODE_CNT; i++) begin : g_excl
            assert_guard_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
                !(guards[i].set && guards[i].clr));
        end

        if (MODE == HB_PRECHARGE) begin : g_pchb
            assert_ack_after_both_R3: assert property (@(posedge clk) disable iff (rst)
                $fell(in_en) |-> $past(in_req && out_req));
            assert_gate_fall_R4: assert property (@(posedge clk) disable iff (rst)
                $fell(nodes.gate) |-> $past(!in_en && !out_en));
            assert_out_clear_R4: assert property (@(posedge clk) disable iff (rst)
                $fell(out_req) |-> $past(!in_en));
            assert_ack_release_R5: assert property (@(posedge clk) disable iff (rst)
                $rose(in_en) |-> $past(!in_req && !out_req));
            assert_gate_rise_R6: assert property (@(posedge clk) disable iff (rst)
                $rose(nodes.gate) |-> $past(in_en && out_en));
            assert_req_gated_R6: assert property (@(posedge clk) disable iff (rst)
                $rose(out_req) |-> $past(nodes.gate));
        end else begin : g_weak
            assert_weak_set_R7: assert property (@(posedge clk) disable iff (rst)
                $rose(out_req) |-> $past(in_req && out_en));
            assert_weak_clr_R7: assert property (@(posedge clk) disable iff (rst)
                $fell(out_req) |-> $past(!in_req && !out_en));
            assert_weak_hold_R8: assert property (@(posedge clk) disable iff (rst)
                $past(in_req != out_en) |-> $stable(out_req));
        end
    endgenerate

endmodule

bind tok_stage tok_stage_chk #(.MODE(MODE)) u_tok_chk (
    .clk     (clk),
    .rst     (rst),
    .in_req  (in_req),
    .in_en   (in_en),
    .out_req (out_req),
    .out_en  (out_en),
    .nodes   (node_q),
    .guards  (guard_all)
);

// File: tb/test_tok_stage.sv
module test_tok_stage;
    import tok_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NST        = 4;
    localparam int TOKENS     = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   n_checks = 0;
    int   n_errors = 0;
    logic run_chain = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

    // directed pre-charge stage
    logic p_in_req = 1'b0, p_out_en = 1'b1, p_in_en, p_out_req;
    tok_stage #(.MODE(HB_PRECHARGE)) i_tok_stage (
        .clk(clk), .rst(rst), .in_req(p_in_req), .in_en(p_in_en),
        .out_req(p_out_req), .out_en(p_out_en));

    // directed weak-condition stage
    logic w_in_req = 1'b0, w_out_en = 1'b1, w_in_en, w_out_req;
    tok_stage #(.MODE(HB_WEAK)) i_tok_stage_weak (
        .clk(clk), .rst(rst), .in_req(w_in_req), .in_en(w_in_en),
        .out_req(w_out_req), .out_en(w_out_en));

    // two chains, one per mode, each with a four-phase producer and consumer
    for (genvar c = 0; c < 2; c++) begin : chain
        logic src_req = 1'b0;
        logic snk_en  = 1'b1;
        logic [NST-1:0] ro_req;
        logic [NST-1:0] lo_en;
        int sent = 0;
        int recv = 0;
        logic dup_seen = 1'b0;

        for (genvar k = 0; k < NST; k++) begin : stg
            tok_stage #(.MODE(c == 0 ? HB_PRECHARGE : HB_WEAK)) u_st (
                .clk     (clk),
                .rst     (rst),
                .in_req  ((k == 0) ? src_req : ro_req[(k == 0) ? 0 : k-1]),
                .in_en   (lo_en[k]),
                .out_req (ro_req[k]),
                .out_en  ((k == NST-1) ? snk_en : lo_en[(k == NST-1) ? k : k+1]));
        end

        always @(negedge clk) begin
            if (run_chain) begin
                if (!src_req && lo_en[0] && sent < TOKENS && lfsr[c*4]) begin
                    src_req = 1'b1;
                    sent++;
                end else if (src_req && !lo_en[0] && lfsr[c*4+1]) begin
                    src_req = 1'b0;
                end
                if (ro_req[NST-1] && snk_en && lfsr[c*4+2]) begin
                    snk_en = 1'b0;
                    recv++;
                    if (recv > sent) dup_seen = 1'b1;
                end else if (!ro_req[NST-1] && !snk_en && lfsr[c*4+3]) begin
                    snk_en = 1'b1;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        step(3);
        rst = 1'b0;
        chk("R1", "pchb out_req after reset", p_out_req, 0);
        chk("R1", "pchb in_en after reset", p_in_en, 1);
        chk("R1", "weak out_req after reset", w_out_req, 0);
        chk("R1", "weak in_en after reset", w_in_en, 1);
    endtask

    task automatic t_pchb_full_cycle;
        p_in_req = 1'b1;
        step(1);
        chk("R2", "out_req one clock after in_req", p_out_req, 1);
        chk("R3", "in_en still high before ack", p_in_en, 1);
        step(1);
        chk("R3", "in_en falls after in_req and out_req", p_in_en, 0);
        step(3);
        chk("R4", "out_req kept while out_en high", p_out_req, 1);
        chk("R8", "in_en held low", p_in_en, 0);
        p_in_req = 1'b0;
        step(3);
        chk("R5", "in_en low while out_req high", p_in_en, 0);
        chk("R4", "out_req kept, out_en still high", p_out_req, 1);
        p_out_en = 1'b0;
        step(1);
        chk("R4", "out_req one clock after both enables low", p_out_req, 1);
        step(1);
        chk("R4", "out_req cleared after gate fell", p_out_req, 0);
        chk("R5", "in_en still low same clock", p_in_en, 0);
        step(1);
        chk("R5", "in_en back high", p_in_en, 1);
        p_in_req = 1'b1;
        step(3);
        chk("R6", "out_req blocked while gate low", p_out_req, 0);
        p_out_en = 1'b1;
        step(1);
        chk("R6", "out_req waits for gate rise", p_out_req, 0);
        step(1);
        chk("R6", "out_req after gate re-armed", p_out_req, 1);
        step(1);
        p_in_req = 1'b0;
        p_out_en = 1'b0;
        step(4);
        p_out_en = 1'b1;
        step(2);
        chk("R5", "stage idle again in_en", p_in_en, 1);
        chk("R4", "stage idle again out_req", p_out_req, 0);
    endtask

    task automatic t_pchb_early_right;
        p_in_req = 1'b1;
        step(1);
        chk("R2", "out_req raised", p_out_req, 1);
        p_out_en = 1'b0;
        step(1);
        chk("R3", "in_en falls", p_in_en, 0);
        chk("R4", "out_req kept, in_en was high", p_out_req, 1);
        step(1);
        chk("R4", "out_req kept while gate falls", p_out_req, 1);
        step(1);
        chk("R4", "out_req clears after gate low", p_out_req, 0);
        chk("R5", "in_en low while in_req high", p_in_en, 0);
        p_in_req = 1'b0;
        step(1);
        chk("R5", "in_en rises after both low", p_in_en, 1);
        p_out_en = 1'b1;
        step(2);
        chk("R6", "idle out_req", p_out_req, 0);
    endtask

    task automatic t_weak;
        w_in_req = 1'b1;
        step(1);
        chk("R7", "weak out_req set", w_out_req, 1);
        chk("R7", "weak in_en inverse", w_in_en, 0);
        w_out_en = 1'b0;
        step(2);
        chk("R8", "weak out_req held, inputs disagree", w_out_req, 1);
        w_in_req = 1'b0;
        step(1);
        chk("R7", "weak out_req cleared", w_out_req, 0);
        chk("R7", "weak in_en inverse after clear", w_in_en, 1);
        w_in_req = 1'b1;
        step(2);
        chk("R8", "weak out_req held low, inputs disagree", w_out_req, 0);
        w_out_en = 1'b1;
        step(1);
        chk("R7", "weak out_req set after enable", w_out_req, 1);
        w_in_req = 1'b0;
        w_out_en = 1'b0;
        step(1);
        chk("R7", "weak out_req cleared again", w_out_req, 0);
        w_out_en = 1'b1;
        step(1);
    endtask

    task automatic t_chains;
        int waited = 0;
        run_chain = 1'b1;
        while ((chain[0].recv < TOKENS || chain[1].recv < TOKENS) && waited < 40000) begin
            step(1);
            waited++;
        end
        while ((chain[0].snk_en == 1'b0 || chain[1].snk_en == 1'b0 ||
                chain[0].src_req || chain[1].src_req) && waited < 40000) begin
            step(1);
            waited++;
        end
        step(2 * NST + 8);
        run_chain = 1'b0;
        chk("R10", "pchb chain tokens delivered", chain[0].recv, TOKENS);
        chk("R10", "weak chain tokens delivered", chain[1].recv, TOKENS);
        chk("R10", "pchb chain no duplicate", chain[0].dup_seen, 0);
        chk("R10", "weak chain no duplicate", chain[1].dup_seen, 0);
        chk("R10", "pchb chain drained", chain[0].ro_req[NST-1], 0);
        chk("R10", "weak chain drained", chain[1].ro_req[NST-1], 0);
        chk("R10", "pchb chain head ready", chain[0].lo_en[0], 1);
        chk("R10", "weak chain head ready", chain[1].lo_en[0], 1);
    endtask

    logic finished = 1'b0;

    initial begin
        t_reset();
        t_pchb_full_cycle();
        t_pchb_early_right();
        t_weak();
        t_chains();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule